// File: doc/BRIEF.md
# Serial flash command sequencer

This block converts single-cycle command strobes from user logic into complete transactions on a four-wire serial flash bus (clock, active-low select, data out, data in). It covers the common maintenance and data operations of a serial NOR flash: reading the capacity ID, reading the status byte, single-byte normal and fast reads, single-byte page writes, writing protection bits, sector and bulk erase, and switching between 3-byte and 4-byte addressing. Commands that modify the array or the protection bits are sent automatically as a pair of frames. The first frame carries the write-enable opcode and the second carries the command itself.

User logic raises one bit of `cmd_req_i` for a cycle, with the address and write byte alongside. It then watches `busy_o`. A result byte appears on `rdata_o` with a one-cycle `rdata_valid_o` pulse in the final busy cycle, and it stays there after `busy_o` falls. After every transaction the block holds a two-cycle recovery window in which new strobes are discarded. The serial clock is produced from the input clock, one serial bit for every two input clocks.

Top module: `sflash_seq`

## Requirements
- R1: A strobe on `cmd_req_i` is sampled on the rising clock edge. When the block is idle and accepts it, `busy_o` is high from the next cycle until the transaction is complete. `busy_o` never rises without a strobe on the previous edge.
- R2: Command index by bit of `cmd_req_i`: 0 read ID, 1 read status, 2 read, 3 fast read, 4 page write, 5 protect, 6 sector erase, 7 bulk erase, 8 enter 4-byte mode, 9 leave 4-byte mode. When several bits are set together, the lowest index is executed and the others are dropped.
- R3: Commands 0 to 3 return the byte read from the flash on `rdata_o`. `rdata_valid_o` pulses for exactly one cycle, and that cycle is the last one with `busy_o` high. `rdata_o` is unchanged when `busy_o` falls. Other commands give no pulse.
- R4: During the two cycles that follow the fall of `busy_o`, strobes are ignored. A strobe in the third cycle is accepted.
- R5: Opcodes sent: 0x9F, 0x05, 0x03, 0x0B, 0x02, 0x01 (protect, followed by `wdata_i`), 0xD8, 0xC7, 0xB7, 0xE9.
- R6: Commands 4 to 7 first send a separate one-byte frame with opcode 0x06. Select goes high between that frame and the command frame.
- R7: Address phases carry `addr_i[23:0]` after reset and after command 9. After command 8 they carry all 32 bits of `addr_i`.
- R8: A fast read inserts 8 dummy serial clocks, with data out low, between the address and the data byte.
- R9: Each field is shifted MSB first. `mosi_o` changes only when `sck_o` falls, and `miso_i` is sampled when `sck_o` rises.
- R10: `cs_no` falls at least one clock before the first rise of `sck_o`. `cs_no` rises at least one clock after the last fall of `sck_o`. `sck_o` is high only while `cs_no` is low.
- R11: At reset and whenever `busy_o` is low, `cs_no` is high and `sck_o` is low. `sck_o` runs at half the input clock rate during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; also the source of the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_req_i | input | 10 | One strobe bit for each command index |
| addr_i | input | 32 | Flash address, sampled with the strobe |
| wdata_i | input | 8 | Byte for page write or protect, sampled with the strobe |
| busy_o | output | 1 | Transaction in progress |
| rdata_o | output | 8 | Last byte read from the flash |
| rdata_valid_o | output | 1 | One-cycle pulse marking a new `rdata_o` |
| sck_o | output | 1 | Serial clock to the flash |
| cs_no | output | 1 | Flash select, active low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
A 4-byte mode flag left in the wrong state appears on the very next addressed frame, as an address phase eight bits too long or too short. The sweep covers every command in both modes so that this is always seen. A bit counter that is off by one in the shift engine appears within the same transaction, either as a rotated result byte or as a frame length that differs from the computed one. A sequencer that leaves its recovery window too early, or stays in it too long, appears as a strobe that is accepted too soon or one that is lost in the third cycle after `busy_o` falls.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int NUM_CMDS = 10;
  localparam int FRAME_W  = 48;  // opcode + 32-bit address + data byte
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [3:0] {
    CMD_RD_ID      = 4'd0,
    CMD_RD_STAT    = 4'd1,
    CMD_READ       = 4'd2,
    CMD_FAST_READ  = 4'd3,
    CMD_PAGE_WR    = 4'd4,
    CMD_PROTECT    = 4'd5,
    CMD_SECT_ERASE = 4'd6,
    CMD_BULK_ERASE = 4'd7,
    CMD_ADDR4_ON   = 4'd8,
    CMD_ADDR4_OFF  = 4'd9
  } cmd_e;

  function automatic logic [7:0] cmd_opcode(cmd_e c);
    case (c)
      CMD_RD_ID:      return 8'h9F;
      CMD_RD_STAT:    return 8'h05;
      CMD_READ:       return 8'h03;
      CMD_FAST_READ:  return 8'h0B;
      CMD_PAGE_WR:    return 8'h02;
      CMD_PROTECT:    return 8'h01;
      CMD_SECT_ERASE: return 8'hD8;
      CMD_BULK_ERASE: return 8'hC7;
      CMD_ADDR4_ON:   return 8'hB7;
      default:        return 8'hE9;
    endcase
  endfunction

  function automatic logic cmd_has_addr(cmd_e c);
    return c inside {CMD_READ, CMD_FAST_READ, CMD_PAGE_WR, CMD_SECT_ERASE};
  endfunction

  function automatic logic cmd_has_wdata(cmd_e c);
    return c inside {CMD_PAGE_WR, CMD_PROTECT};
  endfunction

  function automatic logic cmd_is_read(cmd_e c);
    return c inside {CMD_RD_ID, CMD_RD_STAT, CMD_READ, CMD_FAST_READ};
  endfunction

  function automatic logic cmd_needs_wren(cmd_e c);
    return c inside {CMD_PAGE_WR, CMD_PROTECT, CMD_SECT_ERASE, CMD_BULK_ERASE};
  endfunction
endpackage

// File: rtl/sflash_cmd_arb.sv
module sflash_cmd_arb
  import sflash_pkg::*;
#(
  parameter int N = NUM_CMDS
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output cmd_e         cmd_o
);
  always_comb begin
    valid_o = |req_i;
    cmd_o   = CMD_RD_ID;
    // walk downward so the lowest set index is the last assignment
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) cmd_o = cmd_e'(4'(i));
    end
  end
endmodule

// File: rtl/sflash_frame_build.sv
module sflash_frame_build
  import sflash_pkg::*;
#(
  parameter int DUMMY_CLKS = 8,
  parameter int CNT_W      = 8
) (
  input  cmd_e               cmd_i,
  input  logic               wren_i,
  input  logic               addr4_i,
  input  logic [31:0]        addr_i,
  input  logic [7:0]         wdata_i,
  output logic [FRAME_W-1:0] tx_o,
  output logic [CNT_W-1:0]   tx_len_o,
  output logic [CNT_W-1:0]   dummy_o,
  output logic [CNT_W-1:0]   rx_len_o
);
  localparam int OP_HI = FRAME_W - 1;
  localparam int AD_HI = FRAME_W - 9;

  always_comb begin
    tx_o     = '0;
    tx_len_o = CNT_W'(8);
    dummy_o  = '0;
    rx_len_o = '0;
    if (wren_i) begin
      tx_o[OP_HI -: 8] = OP_WREN;
    end else begin
      tx_o[OP_HI -: 8] = cmd_opcode(cmd_i);
      if (cmd_has_addr(cmd_i)) begin
        if (addr4_i) begin
          tx_o[AD_HI -: 32] = addr_i;
          tx_len_o = tx_len_o + CNT_W'(32);
        end else begin
          tx_o[AD_HI -: 24] = addr_i[23:0];
          tx_len_o = tx_len_o + CNT_W'(24);
        end
      end
      if (cmd_has_wdata(cmd_i)) begin
        if (!cmd_has_addr(cmd_i)) tx_o[AD_HI -: 8] = wdata_i;
        else if (addr4_i)         tx_o[AD_HI - 32 -: 8] = wdata_i;
        else                      tx_o[AD_HI - 24 -: 8] = wdata_i;
        tx_len_o = tx_len_o + CNT_W'(8);
      end
      if (cmd_i == CMD_FAST_READ) dummy_o = CNT_W'(DUMMY_CLKS);
      if (cmd_is_read(cmd_i)) rx_len_o = CNT_W'(8);
    end
  end
endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter #(
  parameter int FW   = 48,
  parameter int CW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] tx_i,
  input  logic [CW-1:0] tx_len_i,
  input  logic [CW-1:0] dummy_i,
  input  logic [CW-1:0] rx_len_i,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          cs_no,
  output logic          mosi_o,
  output logic [7:0]    rx_o,
  output logic          done_o
);
  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_HOLD} est_e;

  est_e          st_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] total_q, cnt_q;
  logic [7:0]    rx_q;
  logic          sck_q, cs_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= E_IDLE;
      sh_q    <= '0;
      total_q <= '0;
      cnt_q   <= '0;
      rx_q    <= '0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        E_IDLE: if (start_i) begin
          sh_q    <= tx_i;
          total_q <= tx_len_i + dummy_i + rx_len_i;
          cnt_q   <= '0;
          cs_q    <= 1'b0;  // one clock of select before the first rising edge
          st_q    <= E_SHIFT;
        end
        E_SHIFT: begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            sh_q  <= sh_q << 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == total_q - 1'b1) st_q <= E_HOLD;
          end
        end
        default: begin
          cs_q   <= 1'b1;
          done_q <= 1'b1;
          st_q   <= E_IDLE;
        end
      endcase
    end
  end

  assign sck_o  = sck_q;
  assign cs_no  = cs_q;
  assign mosi_o = sh_q[FW-1];
  assign rx_o   = rx_q;
  assign done_o = done_q;
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int DUMMY_CLKS = 8,
  parameter int GAP_CYCLES = 2,
  parameter int CNT_W      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CMDS-1:0] cmd_req_i,
  input  logic [31:0]         addr_i,
  input  logic [7:0]          wdata_i,
  output logic                busy_o,
  output logic [7:0]          rdata_o,
  output logic                rdata_valid_o,
  output logic                sck_o,
  output logic                cs_no,
  output logic                mosi_o,
  input  logic                miso_i
);
  localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  typedef enum logic [2:0] {
    T_IDLE, T_WREN_GO, T_WREN_RUN, T_MAIN_GO, T_MAIN_RUN, T_LAST, T_GAP
  } tst_e;

  tst_e        st_q;
  cmd_e        cmd_q, arb_cmd;
  logic [31:0] addr_q;
  logic [7:0]  wdata_q, rdata_q, rx_byte;
  logic        addr4_q, rvalid_q, arb_valid, start, eng_done;
  logic [GAP_W-1:0] gap_q;
  logic [NUM_CMDS-1:0] req_gated;
  logic [FRAME_W-1:0]  tx;
  logic [CNT_W-1:0]    tx_len, dummy_len, rx_len;

  assign req_gated = (st_q == T_IDLE) ? cmd_req_i : '0;

  sflash_cmd_arb #(.N(NUM_CMDS)) arb_i (
    .req_i  (req_gated),
    .valid_o(arb_valid),
    .cmd_o  (arb_cmd)
  );

  sflash_frame_build #(.DUMMY_CLKS(DUMMY_CLKS), .CNT_W(CNT_W)) build_i (
    .cmd_i   (cmd_q),
    .wren_i  (st_q == T_WREN_GO),
    .addr4_i (addr4_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .tx_o    (tx),
    .tx_len_o(tx_len),
    .dummy_o (dummy_len),
    .rx_len_o(rx_len)
  );

  assign start = (st_q == T_WREN_GO) || (st_q == T_MAIN_GO);

  sflash_shifter #(.FW(FRAME_W), .CW(CNT_W)) shift_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tx_i    (tx),
    .tx_len_i(tx_len),
    .dummy_i (dummy_len),
    .rx_len_i(rx_len),
    .miso_i  (miso_i),
    .sck_o   (sck_o),
    .cs_no   (cs_no),
    .mosi_o  (mosi_o),
    .rx_o    (rx_byte),
    .done_o  (eng_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= T_IDLE;
      cmd_q    <= CMD_RD_ID;
      addr_q   <= '0;
      wdata_q  <= '0;
      addr4_q  <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      gap_q    <= '0;
    end else begin
      case (st_q)
        T_IDLE: if (arb_valid) begin
          cmd_q   <= arb_cmd;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          st_q    <= cmd_needs_wren(arb_cmd) ? T_WREN_GO : T_MAIN_GO;
        end
        T_WREN_GO:  st_q <= T_WREN_RUN;
        T_WREN_RUN: if (eng_done) st_q <= T_MAIN_GO;
        T_MAIN_GO:  st_q <= T_MAIN_RUN;
        T_MAIN_RUN: if (eng_done) begin
          if (cmd_is_read(cmd_q)) rdata_q <= rx_byte;
          rvalid_q <= cmd_is_read(cmd_q);
          if (cmd_q == CMD_ADDR4_ON)  addr4_q <= 1'b1;
          if (cmd_q == CMD_ADDR4_OFF) addr4_q <= 1'b0;
          st_q <= T_LAST;
        end
        T_LAST: begin
          rvalid_q <= 1'b0;
          gap_q    <= GAP_W'(GAP_CYCLES - 1);
          st_q     <= T_GAP;
        end
        default: begin
          if (gap_q == '0) st_q <= T_IDLE;
          else gap_q <= gap_q - 1'b1;
        end
      endcase
    end
  end

  assign busy_o        = (st_q != T_IDLE) && (st_q != T_GAP);
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
endmodule

// File: rtl/sflash_seq_chk.sv
module sflash_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [9:0] cmd_req_i,
  input logic       busy_o,
  input logic [7:0] rdata_o,
  input logic       rdata_valid_o,
  input logic       sck_o,
  input logic       cs_no,
  input logic       mosi_o
);
  assert_busy_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(|cmd_req_i));

  assert_valid_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> busy_o);

  assert_valid_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !busy_o);

  assert_data_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $stable(rdata_o));

  assert_gap_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> !busy_o);

  assert_gap_second_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> ##1 !busy_o);

  assert_mosi_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o));

  assert_sck_in_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);

  assert_cs_setup_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sck_o);

  assert_cs_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> !$past(sck_o));

  assert_idle_bus_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sck_o));
endmodule

bind sflash_seq sflash_seq_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_req_i    (cmd_req_i),
  .busy_o       (busy_o),
  .rdata_o      (rdata_o),
  .rdata_valid_o(rdata_valid_o),
  .sck_o        (sck_o),
  .cs_no        (cs_no),
  .mosi_o       (mosi_o)
);

// File: tb/sflash_seq_tb_top.sv
`timescale 1ns/1ps
module sflash_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  cmd_req_i = '0;
  logic [31:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        busy_o, rdata_valid_o, sck_o, cs_no, mosi_o, miso_i;
  logic [7:0]  rdata_o;

  always #4 clk = ~clk;

  sflash_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_req_i(cmd_req_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .busy_o(busy_o), .rdata_o(rdata_o),
    .rdata_valid_o(rdata_valid_o), .sck_o(sck_o), .cs_no(cs_no),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int tests = 0, fails = 0, mtests = 0, mfails = 0;
  bit four = 0;

  // flash responder and frame monitor, all sampled away from the clock edge
  logic [7:0]  resp_q = 8'h00;
  logic [31:0] fall_cnt = '0;
  logic        prev_cs = 1'b1, prev_sck = 1'b0, first_rise = 1'b0;
  logic [63:0] cur_b = '0;
  int          cur_n = 0, nf = 0, cyc_n = 0, cs_fall_cyc = 0, last_fall_cyc = 0;
  logic [63:0] fr_bits [64];
  int          fr_len  [64];

  assign miso_i = resp_q[~fall_cnt[2:0]];

  always @(negedge clk) begin
    cyc_n <= cyc_n + 1;
    if (prev_cs && !cs_no) begin
      cur_b = '0; cur_n = 0; fall_cnt = '0; cs_fall_cyc = cyc_n; first_rise = 1'b1;
    end
    if (!prev_sck && sck_o) begin
      if (first_rise) begin
        mtests++;
        if (cyc_n - cs_fall_cyc < 1) begin
          mfails++;
          $display("FAIL R10 select setup actual=%0d expected>=1", cyc_n - cs_fall_cyc);
        end
        first_rise = 1'b0;
      end
      cur_b = {cur_b[62:0], mosi_o};
      cur_n++;
    end
    if (prev_sck && !sck_o) begin
      fall_cnt = fall_cnt + 1;
      last_fall_cyc = cyc_n;
    end
    if (!prev_cs && cs_no) begin
      mtests++;
      if (cyc_n - last_fall_cyc < 1) begin
        mfails++;
        $display("FAIL R10 select hold actual=%0d expected>=1", cyc_n - last_fall_cyc);
      end
      if (nf < 64) begin fr_bits[nf] = cur_b; fr_len[nf] = cur_n; end
      nf++;
    end
    prev_cs  = cs_no;
    prev_sck = sck_o;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void exp_frame(input int idx, input logic [31:0] a, input logic [7:0] d,
                                    input bit fb, output logic [63:0] b, output int n);
    logic [7:0] op;
    case (idx)
      0: op = 8'h9F; 1: op = 8'h05; 2: op = 8'h03; 3: op = 8'h0B; 4: op = 8'h02;
      5: op = 8'h01; 6: op = 8'hD8; 7: op = 8'hC7; 8: op = 8'hB7; default: op = 8'hE9;
    endcase
    b = {56'b0, op}; n = 8;
    if (idx == 2 || idx == 3 || idx == 4 || idx == 6) begin
      if (fb) begin b = (b << 32) | {32'b0, a}; n += 32; end
      else    begin b = (b << 24) | {40'b0, a[23:0]}; n += 24; end
    end
    if (idx == 4 || idx == 5) begin b = (b << 8) | {56'b0, d}; n += 8; end
    if (idx == 3) begin b = b << 8; n += 8; end
    if (idx <= 3) begin b = b << 8; n += 8; end
  endfunction

  task automatic do_cmd(input int idx, input logic [31:0] a, input logic [7:0] d,
                        input logic [7:0] r, input logic [9:0] extra, input bit probe);
    int base, vcnt, guard, k, en;
    bit prev_valid;
    logic [63:0] eb;
    string tag;
    resp_q = r;
    base = nf;
    @(negedge clk);
    cmd_req_i = 10'(1 << idx) | extra;
    addr_i = a; wdata_i = d;
    @(negedge clk);
    cmd_req_i = '0;
    check("R1 busy after strobe", 64'(busy_o), 64'd1);
    vcnt = 0; prev_valid = 0; guard = 0;
    while (busy_o && guard < 5000) begin
      prev_valid = rdata_valid_o;
      if (rdata_valid_o) vcnt++;
      @(negedge clk);
      guard++;
    end
    check("R1 busy released", 64'(guard < 5000), 64'd1);
    if (idx <= 3) begin
      check("R3 single valid pulse", 64'(vcnt), 64'd1);
      check("R3 valid in last busy cycle", 64'(prev_valid), 64'd1);
      check("R3 read byte", 64'(rdata_o), 64'(r));
    end else begin
      check("R3 no valid pulse", 64'(vcnt), 64'd0);
    end
    k = base;
    if (idx >= 4 && idx <= 7) begin
      check("R6 frame count", 64'(nf - base), 64'd2);
      check("R6 write enable frame", fr_bits[k], 64'h06);
      check("R6 write enable length", 64'(fr_len[k]), 64'd8);
      k++;
    end else begin
      check("R2 frame count", 64'(nf - base), 64'd1);
    end
    exp_frame(idx, a, d, four, eb, en);
    tag = (idx == 3) ? "R8" : ((idx == 2 || idx == 4 || idx == 6) ? "R7" : "R5");
    check({tag, " R9 frame bits"}, fr_bits[k], eb);
    check({tag, " frame length"}, 64'(fr_len[k]), 64'(en));
    if (idx == 8) four = 1;
    if (idx == 9) four = 0;
    if (probe) begin
      base = nf;
      cmd_req_i = 10'h002;
      @(negedge clk);
      check("R4 first gap cycle ignored", 64'(busy_o), 64'd0);
      @(negedge clk);
      cmd_req_i = '0;
      check("R4 second gap cycle ignored", 64'(busy_o), 64'd0);
      @(negedge clk);
      check("R4 no frame from gap strobe", 64'(nf - base), 64'd0);
      check("R4 still idle", 64'(busy_o), 64'd0);
    end else begin
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests + mtests + 1, fails + mfails + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R11 reset busy", 64'(busy_o), 64'd0);
    check("R11 reset select", 64'(cs_no), 64'd1);
    check("R11 reset clock", 64'(sck_o), 64'd0);
    check("R3 reset valid", 64'(rdata_valid_o), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // full sweep of commands in both address widths
    for (int m = 0; m < 2; m++) begin
      if (m == 1) do_cmd(8, 32'h0, 8'h0, 8'h00, '0, 0);
      for (int idx = 0; idx < 8; idx++) begin
        do_cmd(idx, 32'hC3A5_96E1 + 32'(idx) * 32'h0102_0304, 8'h3C + 8'(idx),
               8'h5A ^ 8'(idx * 37 + m * 91), '0, 0);
      end
      if (m == 1) do_cmd(9, 32'h0, 8'h0, 8'h00, '0, 0);
    end
    // R7 address back to 24 bits after leaving 4-byte mode
    do_cmd(2, 32'hFFEE_DDCC, 8'h00, 8'h81, '0, 0);
    // R2 priority among simultaneous strobes
    do_cmd(1, 32'h0, 8'h00, 8'hE7, 10'b10_0010_1000, 0);
    do_cmd(6, 32'h0012_3456, 8'h00, 8'h00, 10'b01_1000_0000, 0);
    do_cmd(0, 32'h0, 8'h00, 8'h18, 10'b11_1111_1110, 0);
    // R4 recovery window, then acceptance on the third cycle
    do_cmd(0, 32'h0, 8'h00, 8'hA3, '0, 1);
    do_cmd(3, 32'h00AB_CDEF, 8'h00, 8'h01, '0, 0);
    do_cmd(2, 32'h0000_0001, 8'h00, 8'hFE, '0, 1);
    do_cmd(5, 32'h0, 8'h9C, 8'h00, '0, 0);
    check("R11 idle select after run", 64'(cs_no), 64'd1);
    $display("[TB] %0d tests run, %0d failed", tests + mtests, fails + mfails);
    $finish;
  end
endmodule